// File: doc/BRIEF.md
# Stall-Based DVFS Performance Predictor

This block watches the oldest entry of an out-of-order core's reorder buffer while the core runs, and uses two counters to estimate how the same stretch of work would behave at a lower clock. Software or a power controller opens a measurement window with `win_start` and closes it with `win_stop`. Inside the window one counter adds up every cycle. The other adds up the cycles in which the oldest reorder-buffer entry is a load still waiting on an off-chip miss.

The model behind the prediction treats a slower clock as a memory latency that is shorter when counted in cycles. Stall cycles shrink in proportion to the frequency divisor. Non-stall cycles are taken as fixed. When the window closes, the block takes a slowdown divisor `k` and a measured-frequency ratio `l`, both unsigned fixed point with 8 fractional bits. If the window was measured below full speed, it first scales the stall count up to full speed. It then runs a multi-cycle restoring division and presents the predicted cycle count and the predicted execution time, expressed in full-speed clock periods. A one-cycle strobe marks that both predictions are ready.

Top module: `dvfs_stall_predictor`

## Requirements
- R1: A cycle with `win_start` high clears both counters, `pred_cycles`, `pred_time`, `busy` and `result_valid` at the next edge and opens a window. It also abandons any computation still in progress. It takes priority over `win_stop` and over a computation finishing in the same cycle.
- R2: `cyc_total` rises by one for every cycle of an open window, from the cycle after the start cycle up to and including the stop cycle.
- R3: `cyc_stall` rises by one only in window cycles where `head_miss_pending` is high. While no window is open, `head_miss_pending` leaves both counters unchanged, and `cyc_stall` never exceeds `cyc_total`.
- R4: Both counters stop at all-ones and never wrap back to zero.
- R5: A `win_stop` in an open window closes it and samples `div_k` and `ratio_l` in that cycle. `busy` is then high for exactly CNT_W+FX_W+FRAC+2 cycles.
- R6: With c = `cyc_total`, S = `cyc_stall`, and `div_k` and `ratio_l` read as integers scaled by 256 (256 means 1.0), `pred_cycles` = (c−S)·256 + floor(S·l·256 / k). This is the predicted cycle count with 8 fractional bits. If k = 0, the quotient term is all-ones of width CNT_W+FX_W+FRAC.
- R7: `pred_time` = (c−S)·k + S·l, using the same scaled integers. This is the predicted run time in full-speed clock periods with 8 fractional bits.
- R8: `result_valid` is high for exactly one cycle, in the first cycle that `busy` is low again. After that, both predictions hold their values until the next window start.
- R9: A `win_stop` while no window is open has no effect: `busy` stays low and the counters and predictions keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_start | input | 1 | Clear the counters and open a measurement window |
| win_stop | input | 1 | Close the window and begin the prediction |
| head_miss_pending | input | 1 | Oldest reorder-buffer entry is a load waiting on an off-chip miss |
| div_k | input | FX_W | Slowdown divisor k, 8 fractional bits |
| ratio_l | input | FX_W | Ratio of full speed to the measured frequency, 8 fractional bits |
| cyc_total | output | CNT_W | Total cycles counted in the window |
| cyc_stall | output | CNT_W | Stall cycles counted in the window |
| pred_cycles | output | CNT_W+FX_W+FRAC+1 | Predicted cycle count, 8 fractional bits |
| pred_time | output | CNT_W+FX_W+FRAC+1 | Predicted time in full-speed periods, 8 fractional bits |
| busy | output | 1 | Prediction in progress |
| result_valid | output | 1 | One-cycle strobe: predictions updated |

## Verification
Two events can land on the same edge, and the bench provokes both.

The first collision is a new window start arriving on the edge where the divider would otherwise publish its result. The bench closes a window and then raises `win_start` exactly CNT_W+FX_W+FRAC+2 cycles later. The expected outcome is that no strobe appears and both predictions read zero.

The second collision is `win_start` and `win_stop` high together. The window must open and keep counting with `busy` low.

A behavioural model in the bench follows the same priority rules and is compared with every output on every cycle. Any disagreement on either case is therefore caught.

// File: rtl/dvfs_pred_pkg.sv
package dvfs_pred_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_COUNT = 2'd1,
      PH_PREP  = 2'd2,
      PH_DIV   = 2'd3
   } phase_e;
endpackage

// File: rtl/dvfs_sat_counter.sv
module dvfs_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = '1;

   initial begin
      assert (W >= 2) else $error("dvfs_sat_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (clr)               q <= '0;
      else if (en && (q != TOP))  q <= q + 1'b1;
   end
endmodule

// File: rtl/dvfs_restoring_div.sv
module dvfs_restoring_div #(
   parameter int N = 40,
   parameter int D = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         abort,
   input  logic [N-1:0] dvd,
   input  logic [D-1:0] dvs,
   output logic         busy,
   output logic         done,
   output logic [N-1:0] quo
);
   localparam int CW = $clog2(N + 1);
   localparam logic [CW-1:0] ITER = CW'(N);

   logic [D-1:0]  rem_q;
   logic [D-1:0]  dvs_q;
   logic [CW-1:0] left_q;
   logic [D:0]    shifted;
   logic          take;

   initial begin
      assert (N >= 2 && D >= 1) else $error("dvfs_restoring_div: bad widths");
   end

   assign shifted = {rem_q, quo[N-1]};
   assign take    = (shifted >= {1'b0, dvs_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dvs_q  <= '0;
         left_q <= '0;
         quo    <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy <= 1'b0;
         end else if (go) begin
            quo    <= dvd;
            dvs_q  <= dvs;
            rem_q  <= '0;
            left_q <= ITER;
            busy   <= 1'b1;
         end else if (busy) begin
            if (take) begin
               rem_q <= D'(shifted - {1'b0, dvs_q});
               quo   <= {quo[N-2:0], 1'b1};
            end else begin
               rem_q <= shifted[D-1:0];
               quo   <= {quo[N-2:0], 1'b0};
            end
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dvfs_stall_predictor.sv
module dvfs_stall_predictor
   import dvfs_pred_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int FX_W  = 16,
   parameter int FRAC  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            win_start,
   input  logic                            win_stop,
   input  logic                            head_miss_pending,
   input  logic [FX_W-1:0]                 div_k,
   input  logic [FX_W-1:0]                 ratio_l,
   output logic [CNT_W-1:0]                cyc_total,
   output logic [CNT_W-1:0]                cyc_stall,
   output logic [CNT_W+FX_W+FRAC:0]        pred_cycles,
   output logic [CNT_W+FX_W+FRAC:0]        pred_time,
   output logic                            busy,
   output logic                            result_valid
);
   localparam int PROD_W = CNT_W + FX_W;
   localparam int DIV_W  = PROD_W + FRAC;
   localparam int PRED_W = DIV_W + 1;

   initial begin
      assert (CNT_W >= 2)            else $error("dvfs_stall_predictor: CNT_W too small");
      assert (FRAC >= 1 && FRAC < FX_W) else $error("dvfs_stall_predictor: FRAC must be below FX_W");
   end

   phase_e             st_q;
   logic               counting;
   logic               cnt_en;
   logic [FX_W-1:0]    k_q;
   logic [FX_W-1:0]    l_q;
   logic [CNT_W-1:0]   ns_q;
   logic [PRED_W-1:0]  time_q;

   logic [CNT_W-1:0]   ns_now;
   logic [PROD_W-1:0]  stall_scaled;
   logic [DIV_W-1:0]   dividend;
   logic [PRED_W-1:0]  time_now;
   logic               div_go;
   logic               div_busy;
   logic               div_done;
   logic [DIV_W-1:0]   div_quo;

   assign counting = (st_q == PH_COUNT);
   assign cnt_en   = counting && !win_start;

   dvfs_sat_counter #(.W(CNT_W)) u_total (
      .clk (clk), .rst_n (rst_n), .clr (win_start),
      .en  (cnt_en), .q (cyc_total)
   );

   dvfs_sat_counter #(.W(CNT_W)) u_stall (
      .clk (clk), .rst_n (rst_n), .clr (win_start),
      .en  (cnt_en && head_miss_pending), .q (cyc_stall)
   );

   // normalisation to full speed and numerator of the stall term
   assign ns_now       = cyc_total - cyc_stall;
   assign stall_scaled = PROD_W'(cyc_stall) * PROD_W'(l_q);
   assign dividend     = {stall_scaled, {FRAC{1'b0}}};
   assign time_now     = PRED_W'(ns_now) * PRED_W'(k_q) + PRED_W'(stall_scaled);
   assign div_go       = (st_q == PH_PREP) && !win_start;

   dvfs_restoring_div #(.N(DIV_W), .D(FX_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .abort (win_start),
      .dvd   (dividend),
      .dvs   (k_q),
      .busy  (div_busy),
      .done  (div_done),
      .quo   (div_quo)
   );

   assign busy = (st_q == PH_PREP) || (st_q == PH_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= PH_IDLE;
         k_q          <= '0;
         l_q          <= '0;
         ns_q         <= '0;
         time_q       <= '0;
         pred_cycles  <= '0;
         pred_time    <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         if (win_start) begin
            st_q        <= PH_COUNT;
            pred_cycles <= '0;
            pred_time   <= '0;
         end else begin
            unique case (st_q)
               PH_COUNT: if (win_stop) begin
                  st_q <= PH_PREP;
                  k_q  <= div_k;
                  l_q  <= ratio_l;
               end
               PH_PREP: begin
                  ns_q   <= ns_now;
                  time_q <= time_now;
                  st_q   <= PH_DIV;
               end
               PH_DIV: if (div_done && !div_busy) begin
                  pred_cycles  <= PRED_W'({ns_q, {FRAC{1'b0}}}) + PRED_W'(div_quo);
                  pred_time    <= time_q;
                  result_valid <= 1'b1;
                  st_q         <= PH_IDLE;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dvfs_stall_predictor_chk.sv
module dvfs_stall_predictor_chk #(
   parameter int CNT_W = 16,
   parameter int FX_W  = 16,
   parameter int FRAC  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     win_start,
   input logic                     win_stop,
   input logic                     counting,
   input logic [CNT_W-1:0]         cyc_total,
   input logic [CNT_W-1:0]         cyc_stall,
   input logic [CNT_W+FX_W+FRAC:0] pred_cycles,
   input logic [CNT_W+FX_W+FRAC:0] pred_time,
   input logic                     busy,
   input logic                     result_valid
);
   localparam logic [CNT_W-1:0] TOP = '1;

   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_start |=> (cyc_total == '0 && cyc_stall == '0 && !busy && !result_valid));

   assert_stall_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_stall <= cyc_total);

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!counting && !win_start) |=> ($stable(cyc_total) && $stable(cyc_stall)));

   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_total == TOP && !win_start) |=> (cyc_total == TOP));

   assert_stop_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && win_stop && !win_start) |=> busy);

   assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && result_valid));

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !win_start |=> (result_valid || ($stable(pred_cycles) && $stable(pred_time))));

   assert_stray_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!counting && !busy && win_stop && !win_start) |=> !busy);
endmodule

bind dvfs_stall_predictor dvfs_stall_predictor_chk #(
   .CNT_W (CNT_W), .FX_W (FX_W), .FRAC (FRAC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .win_start    (win_start),
   .win_stop     (win_stop),
   .counting     (counting),
   .cyc_total    (cyc_total),
   .cyc_stall    (cyc_stall),
   .pred_cycles  (pred_cycles),
   .pred_time    (pred_time),
   .busy         (busy),
   .result_valid (result_valid)
);

// File: tb/dvfs_stall_predictor_bench.sv
`timescale 1ns/1ps
module dvfs_stall_predictor_bench;
   localparam int CW   = 10;
   localparam int FW   = 16;
   localparam int FR   = 8;
   localparam int DW   = CW + FW + FR;
   localparam int PW   = DW + 1;
   localparam int LAT  = DW + 2;
   localparam longint CMAX = (64'd1 << CW) - 1;
   localparam longint QMAX = (64'd1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic win_start = 1'b0, win_stop = 1'b0, head_miss_pending = 1'b0;
   logic [FW-1:0] div_k = '0, ratio_l = '0;
   logic [CW-1:0] cyc_total, cyc_stall;
   logic [PW-1:0] pred_cycles, pred_time;
   logic busy, result_valid;

   always #4 clk = ~clk;

   dvfs_stall_predictor #(.CNT_W(CW), .FX_W(FW), .FRAC(FR)) u_dvfs_stall_predictor (
      .clk (clk), .rst_n (rst_n), .win_start (win_start), .win_stop (win_stop),
      .head_miss_pending (head_miss_pending), .div_k (div_k), .ratio_l (ratio_l),
      .cyc_total (cyc_total), .cyc_stall (cyc_stall), .pred_cycles (pred_cycles),
      .pred_time (pred_time), .busy (busy), .result_valid (result_valid)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit started = 0;

   // behavioural reference
   longint m_tot, m_stl, m_k, m_l, m_pc, m_pt;
   int     m_left;
   bit     m_cnt, m_busy, m_valid;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tot = 0; m_stl = 0; m_k = 0; m_l = 0; m_pc = 0; m_pt = 0;
         m_left = 0; m_cnt = 0; m_busy = 0; m_valid = 0;
      end else begin
         started = 1;
         m_valid = 0;
         if (win_start) begin
            m_tot = 0; m_stl = 0; m_pc = 0; m_pt = 0;
            m_cnt = 1; m_busy = 0; m_left = 0;
         end else if (m_cnt) begin
            if (m_tot < CMAX) m_tot++;
            if (head_miss_pending && m_stl < CMAX) m_stl++;
            if (win_stop) begin
               m_cnt = 0; m_busy = 1; m_left = LAT;
               m_k = longint'(div_k); m_l = longint'(ratio_l);
            end
         end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               longint ns, q;
               ns = m_tot - m_stl;
               q  = (m_k == 0) ? QMAX : ((m_stl * m_l) << FR) / m_k;
               m_pc = (ns << FR) + q;
               m_pt = ns * m_k + m_stl * m_l;
               m_busy = 0; m_valid = 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         chk("R2 cyc_total", longint'(cyc_total), m_tot);
         chk("R3 cyc_stall", longint'(cyc_stall), m_stl);
         chk("R5 busy", longint'(busy), longint'(m_busy));
         chk("R6 pred_cycles", longint'(pred_cycles), m_pc);
         chk("R7 pred_time", longint'(pred_time), m_pt);
         chk("R8 result_valid", longint'(result_valid), longint'(m_valid));
      end
   end

   function automatic bit pat(int mode, int i);
      case (mode)
         0: return (i % 7) < 3;
         1: return ((i / 10) % 2) == 1;
         2: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic open_win(input int kq, input int lq);
      div_k = FW'(kq); ratio_l = FW'(lq);
      win_start = 1'b1;
      @(negedge clk);
      win_start = 1'b0;
      chk("R1 cleared total", longint'(cyc_total), 0);
      chk("R1 cleared stall", longint'(cyc_stall), 0);
   endtask

   task automatic run_win(input int n, input int kq, input int lq, input int mode);
      open_win(kq, lq);
      for (int i = 0; i < n; i++) begin
         head_miss_pending = pat(mode, i);
         win_stop = (i == n - 1);
         @(negedge clk);
      end
      win_stop = 1'b0;
      head_miss_pending = 1'b0;
   endtask

   bit finished = 0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset total", longint'(cyc_total), 0);
      chk("R8 reset strobe", longint'(result_valid), 0);

      run_win(100, 512, 256, 0);   repeat (LAT + 3) @(negedge clk);
      run_win(77, 384, 512, 1);    repeat (LAT + 3) @(negedge clk);
      run_win(40, 0, 256, 0);      repeat (LAT + 3) @(negedge clk);   // R6 k = 0
      run_win(63, 128, 192, 1);    repeat (LAT + 3) @(negedge clk);
      run_win(30, 256, 256, 3);    repeat (LAT + 3) @(negedge clk);

      // R1: restart while a computation is running
      run_win(50, 700, 300, 0);
      repeat (10) @(negedge clk);
      run_win(20, 300, 256, 2);    repeat (LAT + 3) @(negedge clk);

      // R1: restart on the very edge the result would appear
      run_win(45, 600, 256, 1);
      repeat (LAT - 1) @(negedge clk);
      win_start = 1'b1;
      @(negedge clk);
      win_start = 1'b0;
      chk("R1 strobe suppressed", longint'(result_valid), 0);
      chk("R1 prediction cleared", longint'(pred_cycles), 0);
      repeat (12) @(negedge clk);
      // start and stop together: start wins
      win_start = 1'b1; win_stop = 1'b1;
      @(negedge clk);
      win_start = 1'b0; win_stop = 1'b0;
      chk("R1 start over stop", longint'(busy), 0);
      repeat (5) @(negedge clk);
      win_stop = 1'b1;
      @(negedge clk);
      win_stop = 1'b0;
      repeat (LAT + 3) @(negedge clk);

      // R9 / R3: stray stop and miss flag with no window open
      head_miss_pending = 1'b1; win_stop = 1'b1;
      @(negedge clk);
      win_stop = 1'b0;
      repeat (3) @(negedge clk);
      head_miss_pending = 1'b0;
      chk("R9 stray stop busy", longint'(busy), 0);
      chk("R3 idle miss ignored", longint'(cyc_stall), m_stl);

      // R4: saturation
      run_win(1030, 1000, 256, 2);
      chk("R4 total saturated", longint'(cyc_total), CMAX);
      chk("R4 stall saturated", longint'(cyc_stall), CMAX);
      repeat (LAT + 3) @(negedge clk);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule